// File: doc/BRIEF.md
# I2C memory access sequencer

The sequencer turns one command into the full series of single-byte requests needed to read from, write to, or probe an addressed I2C device. It sits above a byte transfer engine that moves one byte per request and reports success or failure. For every byte the sequencer chooses the bus condition (none, START or STOP), the acknowledge policy (wait for the device's ACK, give ACK, give NACK), the direction and the byte to send.

A read sends a write-addressed chip byte, then the data address most significant byte first. It then issues a repeated START with a read-addressed chip byte and collects the requested number of bytes, giving NACK and STOP on the last one. A write sends the same header and then streams data bytes from a source that advances on `wr_take`. A probe sends a read-addressed chip byte and then one NACKed read with STOP. The engine is reset before each legal transaction and again after it ends. Any failed byte ends the transaction early with a failure status. A single-register access is a transaction with a one-byte address and a count of one.

Top module: `i2c_mem_seq`

## Requirements
- R1: A read or write starts with one request with cond=START (1), ack=WAIT (0), wr=1 and data = {chip, 1'b0}. Encodings: cond 0 none, 1 START, 2 STOP; ack 0 wait for ACK, 1 give ACK, 2 give NACK; wr 1 transmit, 0 receive; data is 0 on receive requests.
- R2: After the chip byte, exactly cmd_alen address requests follow, each with cond=0, ack=0, wr=1. Their data is the address bytes from cmd_addr[8*(alen-1)+:8] down to cmd_addr[7:0], so the most significant byte comes first.
- R3: A read then issues one request with cond=START, ack=WAIT, wr=1 and data = {chip, 1'b1}.
- R4: A read then issues cmd_count receive requests. Every one except the last has cond=0 and ack=1. The byte returned for each read request appears on rd_data with rd_valid high for one cycle, in order, the cycle after the engine's eng_done. No other request raises rd_valid.
- R5: The last read request has cond=STOP and ack=NACK.
- R6: A write sends cmd_count data requests with ack=WAIT and wr=1, taking data from wr_data. wr_take pulses in each such request cycle. Only the last carries cond=STOP; the others have cond=0.
- R7: A probe issues {START, WAIT, wr=1, {chip,1'b1}} and then {STOP, NACK, wr=0}. It ignores cmd_alen and cmd_count, and fail is 0 only when both bytes succeed.
- R8: eng_rst is high for one cycle before the first request of a legal transaction and for one cycle after its last response. No request is made while eng_rst is high.
- R9: A response with eng_ok=0 stops the transaction: no further request is made, eng_rst pulses once, and done rises with fail=1.
- R10: eng_req is a one-cycle pulse. No new request is made until eng_done answers the previous one.
- R11: A command with cmd_op=3, or a read or write (cmd_op 0 or 1) with count 0 or an address length of 0 or above the maximum, raises done with fail=1 in the next cycle. It makes no engine request and no eng_rst pulse.
- R12: cmd_start is ignored while busy is high. The running sequence is unchanged and no second transaction follows.
- R13: During and after reset, busy, done, rd_valid, wr_take, eng_req and eng_rst are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start a command (taken when idle) |
| cmd_op | input | 2 | 0 read, 1 write, 2 probe, 3 illegal |
| cmd_chip | input | 7 | 7-bit device address |
| cmd_addr | input | 24 | Data address, byte k in bits 8k+7:8k |
| cmd_alen | input | 2 | Number of address bytes, 1 to 3 |
| cmd_count | input | 8 | Number of data bytes, at least 1 |
| busy | output | 1 | A transaction is running |
| done | output | 1 | One-cycle end-of-command pulse |
| fail | output | 1 | Status valid with done: 1 failed, 0 success |
| wr_data | input | 8 | Current write byte from the source |
| wr_take | output | 1 | Write byte consumed; source advances |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | rd_data is valid this cycle |
| eng_rst | output | 1 | Reset pulse to the byte engine |
| eng_req | output | 1 | Byte request pulse |
| eng_cond | output | 2 | Bus condition for the byte |
| eng_ack | output | 2 | Acknowledge policy for the byte |
| eng_wr | output | 1 | 1 transmit, 0 receive |
| eng_wdata | output | 8 | Byte to transmit |
| eng_done | input | 1 | Engine finished the requested byte |
| eng_ok | input | 1 | Byte transfer succeeded |
| eng_rdata | input | 8 | Byte received by the engine |

## Verification
On every cycle the assertions check the local rules: requests are single-cycle and never back to back, a NACK policy always comes with STOP on a receive, and every START carries this command's chip address on a transmit. They also check that no request overlaps an engine reset, that done is a pulse, that read data only follows a good engine response, and that an illegal command finishes in one cycle. Only the bench's scenarios show whole orderings. These are the most-significant-first address bytes, the repeated START placed between header and data, the byte counts, and where STOP falls. They also cover the truncation after a failure at a chosen byte, the two engine resets per transaction, and a start pulse ignored while busy.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_PROBE = 2'd2,
      OP_BAD   = 2'd3
   } seq_op_e;

   typedef enum logic [1:0] {
      CND_NONE  = 2'd0,
      CND_START = 2'd1,
      CND_STOP  = 2'd2
   } bcond_e;

   typedef enum logic [1:0] {
      ACK_WAIT = 2'd0,
      ACK_GIVE = 2'd1,
      ACK_NACK = 2'd2
   } back_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PRE,
      ST_CHIPW,
      ST_ADDR,
      ST_CHIPR,
      ST_RD,
      ST_WR,
      ST_PRBA,
      ST_PRBR,
      ST_POST
   } seq_st_e;

   typedef struct packed {
      bcond_e     cond;
      back_e      ack;
      logic       wr;
      logic [7:0] data;
   } byte_req_t;

endpackage

// File: rtl/i2c_seq_chk.sv
module i2c_seq_chk
   import i2c_seq_pkg::*;
#(
   parameter int MAX_AB = 3,
   parameter int CNT_W  = 8,
   localparam int ALEN_W = $clog2(MAX_AB + 1)
) (
   input  seq_op_e           op,
   input  logic [ALEN_W-1:0] alen,
   input  logic [CNT_W-1:0]  count,
   output logic              legal
);

   logic mem_op;
   logic alen_ok;

   assign mem_op  = (op == OP_READ) || (op == OP_WRITE);
   assign alen_ok = (alen != '0) && (int'(alen) <= MAX_AB);
   assign legal   = (op == OP_PROBE) || (mem_op && alen_ok && (count != '0));

endmodule

// File: rtl/i2c_seq_amux.sv
module i2c_seq_amux #(
   parameter int MAX_AB = 3,
   parameter int IDX_W  = 2
) (
   input  logic [8*MAX_AB-1:0] addr,
   input  logic [IDX_W-1:0]    idx,
   output logic [7:0]          sel
);

   logic [7:0] lanes [MAX_AB];

   for (genvar g = 0; g < MAX_AB; g++) begin : g_lane
      assign lanes[g] = addr[8*g +: 8];
   end

   always_comb begin
      sel = '0;
      for (int i = 0; i < MAX_AB; i++) begin
         if (idx == IDX_W'(i)) sel = lanes[i];
      end
   end

endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
   import i2c_seq_pkg::*;
#(
   parameter int MAX_AB = 3,
   parameter int CNT_W  = 8,
   localparam int ALEN_W = $clog2(MAX_AB + 1),
   localparam int IDX_W  = (MAX_AB > 1) ? $clog2(MAX_AB) : 1,
   localparam int AW     = 8 * MAX_AB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  seq_op_e           cmd_op,
   input  logic [6:0]        cmd_chip,
   input  logic [AW-1:0]     cmd_addr,
   input  logic [ALEN_W-1:0] cmd_alen,
   input  logic [CNT_W-1:0]  cmd_count,
   input  logic              cmd_legal,
   input  logic [7:0]        abyte,
   output logic [AW-1:0]     addr_q,
   output logic [IDX_W-1:0]  aidx,
   input  logic [7:0]        wr_data,
   output logic              wr_take,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic              eng_rst,
   output logic              eng_req,
   output byte_req_t         breq,
   input  logic              eng_done,
   input  logic              eng_ok,
   input  logic [7:0]        eng_rdata
);

   seq_st_e          st;
   seq_op_e          op_q;
   logic             pend;
   logic [6:0]       chip_q;
   logic [CNT_W-1:0] cnt_q;
   logic             fail_q;
   logic             last;
   logic             in_byte;

   assign last    = (cnt_q == CNT_W'(1));
   assign in_byte = (st == ST_CHIPW) || (st == ST_ADDR) || (st == ST_CHIPR) ||
                    (st == ST_RD) || (st == ST_WR) || (st == ST_PRBA) || (st == ST_PRBR);
   assign eng_req = in_byte && !pend;
   assign wr_take = eng_req && (st == ST_WR);
   assign eng_rst = (st == ST_PRE) || (st == ST_POST);
   assign busy    = (st != ST_IDLE);

   always_comb begin
      breq = '{cond: CND_NONE, ack: ACK_WAIT, wr: 1'b1, data: 8'h00};
      unique case (st)
         ST_CHIPW: begin
            breq.cond = CND_START;
            breq.data = {chip_q, 1'b0};
         end
         ST_ADDR: breq.data = abyte;
         ST_CHIPR, ST_PRBA: begin
            breq.cond = CND_START;
            breq.data = {chip_q, 1'b1};
         end
         ST_RD: begin
            breq.wr = 1'b0;
            if (last) begin
               breq.cond = CND_STOP;
               breq.ack  = ACK_NACK;
            end else begin
               breq.ack  = ACK_GIVE;
            end
         end
         ST_PRBR: begin
            breq.wr   = 1'b0;
            breq.cond = CND_STOP;
            breq.ack  = ACK_NACK;
         end
         ST_WR: begin
            breq.data = wr_data;
            if (last) breq.cond = CND_STOP;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         op_q     <= OP_READ;
         pend     <= 1'b0;
         chip_q   <= '0;
         addr_q   <= '0;
         aidx     <= '0;
         cnt_q    <= '0;
         fail_q   <= 1'b0;
         done     <= 1'b0;
         fail     <= 1'b0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         done     <= 1'b0;
         rd_valid <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (cmd_start) begin
                  if (cmd_legal) begin
                     st     <= ST_PRE;
                     op_q   <= cmd_op;
                     chip_q <= cmd_chip;
                     addr_q <= cmd_addr;
                     aidx   <= IDX_W'(int'(cmd_alen) - 1);
                     cnt_q  <= cmd_count;
                     fail_q <= 1'b0;
                  end else begin
                     done <= 1'b1;
                     fail <= 1'b1;
                  end
               end
            end
            ST_PRE: begin
               st   <= (op_q == OP_PROBE) ? ST_PRBA : ST_CHIPW;
               pend <= 1'b0;
            end
            ST_POST: begin
               st   <= ST_IDLE;
               done <= 1'b1;
               fail <= fail_q;
            end
            default: begin
               if (!pend) begin
                  pend <= 1'b1;
               end else if (eng_done) begin
                  pend <= 1'b0;
                  if (!eng_ok) begin
                     fail_q <= 1'b1;
                     st     <= ST_POST;
                  end else begin
                     unique case (st)
                        ST_CHIPW: st <= ST_ADDR;
                        ST_ADDR: begin
                           if (aidx == '0) st <= (op_q == OP_READ) ? ST_CHIPR : ST_WR;
                           else            aidx <= aidx - 1'b1;
                        end
                        ST_CHIPR: st <= ST_RD;
                        ST_RD: begin
                           rd_valid <= 1'b1;
                           rd_data  <= eng_rdata;
                           if (last) st <= ST_POST;
                           else      cnt_q <= cnt_q - 1'b1;
                        end
                        ST_WR: begin
                           if (last) st <= ST_POST;
                           else      cnt_q <= cnt_q - 1'b1;
                        end
                        ST_PRBA: st <= ST_PRBR;
                        default: st <= ST_POST;
                     endcase
                  end
               end
            end
         endcase
      end
   end

   // R10: a request is a single-cycle pulse
   a_r10_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req |=> !eng_req);

   // R5: NACK policy only on the closing receive byte
   a_r5_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && breq.ack == ACK_NACK) |-> (breq.cond == CND_STOP && !breq.wr));

   // R1: every START is a transmit of this command's chip address
   a_r1_start_chip: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_req && breq.cond == CND_START) |-> (breq.wr && breq.data[7:1] == chip_q));

   // R8: no request overlaps an engine reset
   a_r8_rst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      eng_rst |-> !eng_req);

   // R4: read data only follows a good engine response
   a_r4_rd_after_ok: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(eng_done && eng_ok));

   // R11: an illegal command finishes at once with failure
   a_r11_illegal: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && !busy && !cmd_legal) |=> (done && fail && !busy));

   // R9: done is a single-cycle pulse
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/i2c_mem_seq.sv
module i2c_mem_seq
   import i2c_seq_pkg::*;
#(
   parameter int MAX_AB = 3,
   parameter int CNT_W  = 8,
   localparam int ALEN_W = $clog2(MAX_AB + 1),
   localparam int IDX_W  = (MAX_AB > 1) ? $clog2(MAX_AB) : 1,
   localparam int AW     = 8 * MAX_AB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic [1:0]        cmd_op,
   input  logic [6:0]        cmd_chip,
   input  logic [AW-1:0]     cmd_addr,
   input  logic [ALEN_W-1:0] cmd_alen,
   input  logic [CNT_W-1:0]  cmd_count,
   output logic              busy,
   output logic              done,
   output logic              fail,
   input  logic [7:0]        wr_data,
   output logic              wr_take,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic              eng_rst,
   output logic              eng_req,
   output logic [1:0]        eng_cond,
   output logic [1:0]        eng_ack,
   output logic              eng_wr,
   output logic [7:0]        eng_wdata,
   input  logic              eng_done,
   input  logic              eng_ok,
   input  logic [7:0]        eng_rdata
);

   if (MAX_AB < 1 || MAX_AB > 4) begin : g_bad_ab
      $error("MAX_AB must lie in 1..4");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W must lie in 1..16");
   end

   seq_op_e          op_e;
   logic             legal;
   logic [AW-1:0]    addr_q;
   logic [IDX_W-1:0] aidx;
   logic [7:0]       abyte;
   byte_req_t        breq;

   assign op_e = seq_op_e'(cmd_op);

   i2c_seq_chk #(.MAX_AB(MAX_AB), .CNT_W(CNT_W)) chk_i (
      .op(op_e), .alen(cmd_alen), .count(cmd_count), .legal(legal)
   );

   i2c_seq_amux #(.MAX_AB(MAX_AB), .IDX_W(IDX_W)) amux_i (
      .addr(addr_q), .idx(aidx), .sel(abyte)
   );

   i2c_seq_fsm #(.MAX_AB(MAX_AB), .CNT_W(CNT_W)) fsm_i (
      .clk(clk), .rst_n(rst_n),
      .cmd_start(cmd_start), .cmd_op(op_e), .cmd_chip(cmd_chip),
      .cmd_addr(cmd_addr), .cmd_alen(cmd_alen), .cmd_count(cmd_count),
      .cmd_legal(legal), .abyte(abyte), .addr_q(addr_q), .aidx(aidx),
      .wr_data(wr_data), .wr_take(wr_take),
      .rd_data(rd_data), .rd_valid(rd_valid),
      .busy(busy), .done(done), .fail(fail),
      .eng_rst(eng_rst), .eng_req(eng_req), .breq(breq),
      .eng_done(eng_done), .eng_ok(eng_ok), .eng_rdata(eng_rdata)
   );

   assign eng_cond  = breq.cond;
   assign eng_ack   = breq.ack;
   assign eng_wr    = breq.wr;
   assign eng_wdata = breq.data;

endmodule

// File: tb/i2c_mem_seq_tb_top.sv
`timescale 1ns/1ps
module i2c_mem_seq_tb_top;

   localparam logic [1:0] C_NONE = 2'd0, C_START = 2'd1, C_STOP = 2'd2;
   localparam logic [1:0] A_WAIT = 2'd0, A_GIVE = 2'd1, A_NACK = 2'd2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0;
   logic [1:0]  cmd_op = '0;
   logic [6:0]  cmd_chip = '0;
   logic [23:0] cmd_addr = '0;
   logic [1:0]  cmd_alen = '0;
   logic [7:0]  cmd_count = '0;
   logic        busy, done, fail;
   logic [7:0]  wr_data;
   logic        wr_take;
   logic [7:0]  rd_data;
   logic        rd_valid;
   logic        eng_rst, eng_req, eng_wr;
   logic [1:0]  eng_cond, eng_ack;
   logic [7:0]  eng_wdata;
   logic        eng_done, eng_ok;
   logic [7:0]  eng_rdata;

   int total = 0;
   int bad = 0;
   int rst_cnt = 0;
   int fail_at = -1;
   int req_num, cur_idx, lat, widx;

   logic [12:0] exp_q[$];
   string       tag_q[$];
   logic [7:0]  rd_q[$];

   always #10 clk = ~clk;

   i2c_mem_seq dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
      .cmd_chip(cmd_chip), .cmd_addr(cmd_addr), .cmd_alen(cmd_alen),
      .cmd_count(cmd_count), .busy(busy), .done(done), .fail(fail),
      .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data),
      .rd_valid(rd_valid), .eng_rst(eng_rst), .eng_req(eng_req),
      .eng_cond(eng_cond), .eng_ack(eng_ack), .eng_wr(eng_wr),
      .eng_wdata(eng_wdata), .eng_done(eng_done), .eng_ok(eng_ok),
      .eng_rdata(eng_rdata)
   );

   assign wr_data = 8'hC0 ^ widx[7:0];

   // byte engine model: answers each request two cycles later
   always @(posedge clk) begin
      eng_done <= 1'b0;
      if (!rst_n) begin
         lat <= 0; req_num <= 0; cur_idx <= 0; widx <= 0;
         eng_ok <= 1'b1; eng_rdata <= '0;
      end else begin
         if (cmd_start && !busy) begin
            req_num <= 0;
            widx    <= 0;
         end
         if (wr_take) widx <= widx + 1;
         if (eng_req) begin
            lat     <= 2;
            cur_idx <= req_num;
            req_num <= req_num + 1;
         end else if (lat != 0) begin
            lat <= lat - 1;
            if (lat == 1) begin
               eng_done  <= 1'b1;
               eng_ok    <= (cur_idx != fail_at);
               eng_rdata <= 8'h30 + cur_idx[7:0];
            end
         end
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // monitor: compares every request and read byte against the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (eng_req) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R10 unexpected request", {19'd0, eng_cond, eng_ack, eng_wr, eng_wdata}, 0);
            end else begin
               logic [12:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check({eng_cond, eng_ack, eng_wr, eng_wdata} == e, t,
                     {19'd0, eng_cond, eng_ack, eng_wr, eng_wdata}, {19'd0, e});
            end
         end
         if (rd_valid) begin
            if (rd_q.size() == 0) begin
               check(1'b0, "R4 unexpected read byte", {24'd0, rd_data}, 0);
            end else begin
               logic [7:0] r;
               r = rd_q.pop_front();
               check(rd_data == r, "R4 read byte", {24'd0, rd_data}, {24'd0, r});
            end
         end
         if (eng_rst) rst_cnt++;
      end
   end

   task automatic push(input int idx, input int f_at, input logic [1:0] c, input logic [1:0] a,
                       input logic w, input logic [7:0] d, input string t);
      if (f_at < 0 || idx <= f_at) begin
         exp_q.push_back({c, a, w, d});
         tag_q.push_back(t);
      end
   endtask

   task automatic run(input int op, input logic [6:0] chip, input logic [23:0] addr,
                      input int alen, input int cnt, input int f_at, input bit poke);
      int  i;
      int  n;
      bit  legal;
      bit  exp_fail;
      bit  seen;
      legal = (op == 2) || ((op < 2) && cnt != 0 && alen >= 1 && alen <= 3);
      i = 0;
      if (legal) begin
         if (op == 2) begin
            push(i, f_at, C_START, A_WAIT, 1'b1, {chip, 1'b1}, "R7 probe address"); i++;
            push(i, f_at, C_STOP,  A_NACK, 1'b0, 8'h00,        "R7 probe read");    i++;
         end else begin
            push(i, f_at, C_START, A_WAIT, 1'b1, {chip, 1'b0}, "R1 chip write byte"); i++;
            for (int k = alen - 1; k >= 0; k--) begin
               push(i, f_at, C_NONE, A_WAIT, 1'b1, addr[8*k +: 8], "R2 address byte"); i++;
            end
            if (op == 0) begin
               push(i, f_at, C_START, A_WAIT, 1'b1, {chip, 1'b1}, "R3 repeated start"); i++;
               for (int j = 0; j < cnt; j++) begin
                  if (j == cnt - 1) push(i, f_at, C_STOP, A_NACK, 1'b0, 8'h00, "R5 last read");
                  else              push(i, f_at, C_NONE, A_GIVE, 1'b0, 8'h00, "R4 read with ack");
                  if (f_at < 0 || i < f_at) rd_q.push_back(8'h30 + i[7:0]);
                  i++;
               end
            end else begin
               for (int j = 0; j < cnt; j++) begin
                  push(i, f_at, (j == cnt - 1) ? C_STOP : C_NONE, A_WAIT, 1'b1,
                       8'hC0 ^ j[7:0], "R6 write byte");
                  i++;
               end
            end
         end
      end
      exp_fail = !legal || (f_at >= 0 && f_at < i);
      fail_at  = f_at;
      rst_cnt  = 0;
      @(negedge clk);
      cmd_op = op[1:0]; cmd_chip = chip; cmd_addr = addr;
      cmd_alen = alen[1:0]; cmd_count = cnt[7:0]; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      n = 0;
      seen = done;
      while (!seen && n < 3000) begin
         if (poke && n == 4) begin
            cmd_op = 2'd1; cmd_chip = 7'h11; cmd_alen = 2'd1; cmd_count = 8'd1; cmd_start = 1'b1;
         end
         if (poke && n == 5) cmd_start = 1'b0;
         @(negedge clk);
         n++;
         seen = done;
      end
      check(seen, "R9 done raised", {31'd0, seen}, 1);
      if (!legal) check(n == 0, "R11 done next cycle", n, 0);
      check(fail == exp_fail, legal ? (f_at >= 0 ? "R9 fail status" : "R7 success status") : "R11 fail status",
            {31'd0, fail}, {31'd0, exp_fail});
      check(rst_cnt == (legal ? 2 : 0), legal ? "R8 engine resets" : "R11 no engine reset", rst_cnt, legal ? 2 : 0);
      repeat (6) @(negedge clk);
      check(exp_q.size() == 0, "R9 requests missing", exp_q.size(), 0);
      check(rd_q.size() == 0, "R4 read bytes missing", rd_q.size(), 0);
      check(!busy, poke ? "R12 no second transaction" : "R12 idle after done", {31'd0, busy}, 0);
      exp_q.delete(); tag_q.delete(); rd_q.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check({busy, done, rd_valid, wr_take, eng_req, eng_rst} == 6'b0, "R13 reset outputs",
            {26'd0, busy, done, rd_valid, wr_take, eng_req, eng_rst}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({busy, done, rd_valid, wr_take, eng_req, eng_rst} == 6'b0, "R13 after reset",
            {26'd0, busy, done, rd_valid, wr_take, eng_req, eng_rst}, 0);
      run(0, 7'h50, 24'h000012, 1, 1, -1, 1'b0);
      run(0, 7'h2A, 24'hABCDEF, 3, 4, -1, 1'b0);
      run(1, 7'h51, 24'h991234, 2, 3, -1, 1'b0);
      run(1, 7'h33, 24'h000077, 1, 1, -1, 1'b0);
      run(2, 7'h48, 24'h000000, 1, 1, -1, 1'b0);
      run(2, 7'h49, 24'h000000, 0, 0, 0, 1'b0);
      run(2, 7'h4A, 24'h000000, 1, 1, 1, 1'b0);
      run(1, 7'h51, 24'h000102, 2, 3, 1, 1'b0);
      run(0, 7'h20, 24'h000005, 1, 4, 5, 1'b0);
      run(0, 7'h20, 24'h000005, 1, 0, -1, 1'b0);
      run(1, 7'h20, 24'h000005, 0, 2, -1, 1'b0);
      run(3, 7'h20, 24'h000005, 1, 1, -1, 1'b0);
      run(1, 7'h5A, 24'h00BEEF, 2, 2, -1, 1'b1);
      run(0, 7'h7F, 24'h000003, 1, 2, -1, 1'b0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule